// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block measures how long a freshly started oscillator has been running, so that the system clock can be moved onto it only after it has settled. Two tick inputs show, one system clock cycle at a time, when each candidate oscillator (a fast one and a slow one) has produced an edge. A select bit picks which of them is timed. The chosen ticks pass through a prescaler that divides by 1, 2, 4 or 8. Every 2^UNIT_LOG2 prescaled ticks make one warm-up unit.

Software loads an 8-bit unit count and pulses `start`. The block latches the select bit, the divider code and the count, and then counts units from zero. When the programmed number of units has elapsed, the timer stops. If the interrupt enable is high in that cycle, the timer sets a sticky request flag. The flag stays set until `irq_clr` is pulsed or a new `start` arrives. The duration is always a whole number of units, so a required time is rounded up to the next unit when the count is chosen.

Top module: `osc_warmup_timer`

## Requirements
- R1: With `src_sel`=0 only `hf_tick` advances the timer; with `src_sel`=1 only `lf_tick` does. Ticks on the source that is not selected have no effect on when the timer expires.
- R2: The divider code selects the prescale ratio: 2'b10 divides by 2, 2'b11 by 1, 2'b01 by 4 and 2'b00 by 8.
- R3: One warm-up unit is 2^UNIT_LOG2 prescaled ticks (128 by default).
- R4: For a count value N from 1 to 255, expiry happens in the cycle that samples the (N × unit × divide ratio)-th selected tick after `start`. `irq` is high from the next clock edge and never earlier.
- R5: A count value of 0 means 256 units. The request flag is set at expiry only if `irq_en` is high in the expiry cycle. Otherwise the expiry leaves `irq` low.
- R6: After expiry the timer stays stopped. Further ticks cannot cause another expiry until the next `start`.
- R7: Once set, `irq` stays high until an `irq_clr` pulse clears it. When the flag is set and cleared in the same cycle, the set wins.
- R8: `start` clears the flag, resets the prescaler and unit counters, and latches the select bit, divider code and count. Changing these inputs during a run has no effect. A `start` in the expiry cycle cancels that expiry.
- R9: After reset `irq` is low and the timer is idle. Ticks arriving before the first `start` cause no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hf_tick | input | 1 | One-cycle pulse per edge of the fast oscillator |
| lf_tick | input | 1 | One-cycle pulse per edge of the slow oscillator |
| src_sel | input | 1 | Timed source: 0 fast, 1 slow |
| div_code | input | 2 | Prescaler ratio code |
| warm_count | input | CNT_W | Warm-up length in units (0 means 2^CNT_W) |
| irq_en | input | 1 | Allows the request flag to be set at expiry |
| start | input | 1 | Latches the configuration and restarts timing |
| irq_clr | input | 1 | Clears the request flag |
| irq | output | 1 | Warm-up-complete request flag |

## Verification
The assertions assume that `start` and `irq_clr` are single-cycle pulses and that the tick inputs are already synchronous to `clk`, with at most one tick per cycle on each source. The bench drives every input only at the falling edge, as a pulse lasting one cycle. It picks tick densities, divider codes and counts at random from a fixed seed, with directed cases for a count of zero, a disabled interrupt, a clear in the expiry cycle and a restart in the expiry cycle. The configuration inputs are scrambled just after each `start`, so the checks rely on the latched values alone.

// File: rtl/owt_pkg.sv
package owt_pkg;

   // log2 of the largest prescale ratio
   localparam int unsigned MAX_DIV_LOG2 = 3;
   localparam int unsigned PRESC_W      = MAX_DIV_LOG2;

   typedef enum logic [1:0] {
      DIV_BY8 = 2'b00,
      DIV_BY4 = 2'b01,
      DIV_BY2 = 2'b10,
      DIV_BY1 = 2'b11
   } owt_div_e;

   typedef struct packed {
      logic     sel;
      owt_div_e div;
   } owt_src_cfg_t;

   // terminal value of the prescaler counter (ratio minus one)
   function automatic logic [PRESC_W-1:0] presc_last(input owt_div_e d);
      case (d)
         DIV_BY1: presc_last = PRESC_W'(0);
         DIV_BY2: presc_last = PRESC_W'(1);
         DIV_BY4: presc_last = PRESC_W'(3);
         default: presc_last = PRESC_W'(7);
      endcase
   endfunction

endpackage

// File: rtl/owt_prescaler.sv
module owt_prescaler
   import owt_pkg::*;
#(
   parameter bit BYPASS = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clear,
   input  logic     tick_in,
   input  owt_div_e div,
   output logic     tick_out
);

   generate
      if (BYPASS) begin : g_bypass
         assign tick_out = tick_in;
      end else begin : g_count
         logic [PRESC_W-1:0] pcnt;
         logic [PRESC_W-1:0] last;

         assign last     = presc_last(div);
         assign tick_out = tick_in && (pcnt == last);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pcnt <= '0;
            else if (clear)    pcnt <= '0;
            else if (tick_out) pcnt <= '0;
            else if (tick_in)  pcnt <= pcnt + 1'b1;
         end

         // R2: phase never passes the ratio chosen by the latched code
         p_presc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> (pcnt <= last));

         // R2: prescaler output only on an input tick
         p_presc_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tick_out |-> tick_in);
      end
   endgenerate

endmodule

// File: rtl/owt_unit_counter.sv
module owt_unit_counter #(
   parameter int unsigned UNIT_LOG2 = 7,
   parameter int unsigned CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ptick,
   input  logic [CNT_W-1:0] count_cfg,
   output logic             running,
   output logic             expire
);

   localparam int unsigned UW = CNT_W + 1;

   logic [UNIT_LOG2-1:0] sub;
   logic [UW-1:0]        units;
   logic [UW-1:0]        target;
   logic                 utick;

   // zero stands for the full range
   assign target = (count_cfg == '0) ? (UW'(1) << CNT_W) : {1'b0, count_cfg};
   assign utick  = running && ptick && (sub == '1);
   assign expire = utick && ((units + 1'b1) == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub     <= '0;
         units   <= '0;
         running <= 1'b0;
      end else if (start) begin
         sub     <= '0;
         units   <= '0;
         running <= 1'b1;
      end else if (running && ptick) begin
         sub <= sub + 1'b1;
         if (expire) begin
            running <= 1'b0;
            units   <= '0;
         end else if (utick) begin
            units <= units + 1'b1;
         end
      end
   end

   // R6: the counter halts once the programmed length has elapsed
   p_stop_after_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !start) |=> !running);

   // R4: the unit count stays below the target while a run is active
   p_units_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (units < target));

   // R6: an idle counter holds its state
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start) |=> (!running && $stable(units)));

endmodule

// File: rtl/owt_irq_flag.sv
module owt_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic expire,
   input  logic enable,
   input  logic clr,
   output logic flag
);

   logic set_req;
   assign set_req = expire && enable && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (start)   flag <= 1'b0;
      else if (set_req) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
   end

   // R5: the flag rises only at an enabled expiry
   p_set_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(expire && enable));

   // R7: the flag holds without a clear or a restart
   p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr && !start) |=> flag);

   // R8: a restart always leaves the flag low
   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !flag);

endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
   import owt_pkg::*;
#(
   parameter int unsigned UNIT_LOG2 = 7,
   parameter int unsigned CNT_W     = 8,
   parameter bit          NO_PRESC  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hf_tick,
   input  logic             lf_tick,
   input  logic             src_sel,
   input  logic [1:0]       div_code,
   input  logic [CNT_W-1:0] warm_count,
   input  logic             irq_en,
   input  logic             start,
   input  logic             irq_clr,
   output logic             irq
);

   generate
      if (UNIT_LOG2 < 1 || UNIT_LOG2 > 16) begin : g_bad_unit
         $error("UNIT_LOG2 must lie in 1..16");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
   endgenerate

   owt_src_cfg_t     cfg;
   logic [CNT_W-1:0] cfg_count;
   logic             running;
   logic             sel_tick;
   logic             ptick;
   logic             expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg       <= '{sel: 1'b0, div: DIV_BY8};
         cfg_count <= '0;
      end else if (start) begin
         cfg       <= '{sel: src_sel, div: owt_div_e'(div_code)};
         cfg_count <= warm_count;
      end
   end

   assign sel_tick = running && (cfg.sel ? lf_tick : hf_tick);

   owt_prescaler #(.BYPASS(NO_PRESC)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .tick_in  (sel_tick),
      .div      (cfg.div),
      .tick_out (ptick)
   );

   owt_unit_counter #(.UNIT_LOG2(UNIT_LOG2), .CNT_W(CNT_W)) u_units (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ptick     (ptick),
      .count_cfg (cfg_count),
      .running   (running),
      .expire    (expire)
   );

   owt_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .expire (expire),
      .enable (irq_en),
      .clr    (irq_clr),
      .flag   (irq)
   );

   // R8: latched settings stay fixed between restarts
   p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(cfg) && $stable(cfg_count)));

   // R9: no request while the timer has never been started or is idle without a flag
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !irq && !start) |=> !irq);

endmodule

// File: tb/sim_osc_warmup_timer.sv
module sim_osc_warmup_timer;

   localparam int UL   = 2;
   localparam int UNIT = 1 << UL;
   localparam int CW   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hf_tick = 1'b0, lf_tick = 1'b0, src_sel = 1'b0;
   logic [1:0]    div_code = 2'b00;
   logic [CW-1:0] warm_count = '0;
   logic          irq_en = 1'b0, start = 1'b0, irq_clr = 1'b0;
   logic          irq;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   osc_warmup_timer #(.UNIT_LOG2(UL), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .lf_tick(lf_tick),
      .src_sel(src_sel), .div_code(div_code), .warm_count(warm_count),
      .irq_en(irq_en), .start(start), .irq_clr(irq_clr), .irq(irq)
   );

   function automatic int div_of(input logic [1:0] c);
      case (c)
         2'b10:   return 2;
         2'b11:   return 1;
         2'b01:   return 4;
         default: return 8;
      endcase
   endfunction

   function automatic int units_of(input logic [CW-1:0] n);
      return (n == 0) ? (1 << CW) : int'(n);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // mode 0: plain run, 1: clear pulse in expiry cycle, 2: restart in expiry cycle
   task automatic run_case(input logic sel, input logic [1:0] dc, input logic [CW-1:0] cnt,
                           input logic ie, input int dens, input int mode);
      int total, n;
      bit early, t;
      @(negedge clk);
      src_sel = sel; div_code = dc; warm_count = cnt; irq_en = ie; start = 1'b1;
      hf_tick = 1'b0; lf_tick = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check(irq === 1'b0, "R8 start clears flag", irq, 0);
      src_sel = ~sel; div_code = 2'($urandom); warm_count = CW'($urandom);
      total = units_of(cnt) * UNIT * div_of(dc);
      n = 0; early = 1'b0;
      while (n < total) begin
         t = (($urandom % 100) < dens);
         if (sel) begin lf_tick = t; hf_tick = 1'($urandom); end
         else     begin hf_tick = t; lf_tick = 1'($urandom); end
         if (t) n++;
         if (t && n == total) begin
            if (mode == 1) irq_clr = 1'b1;
            if (mode == 2) start = 1'b1;
         end
         @(negedge clk);
         hf_tick = 1'b0; lf_tick = 1'b0; irq_clr = 1'b0; start = 1'b0;
         if (n < total && irq !== 1'b0) early = 1'b1;
      end
      check(!early, "R4 R1 no request before final tick", int'(early), 0);
      if (mode == 2) begin
         check(irq === 1'b0, "R8 restart cancels expiry", irq, 0);
         return;
      end
      if (mode == 1) check(irq === ie, "R7 set wins over clear", irq, ie);
      else           check(irq === ie, "R4 R5 R2 R3 expiry request", irq, ie);
      repeat (5) begin
         hf_tick = 1'b1; lf_tick = 1'b1;
         @(negedge clk);
      end
      hf_tick = 1'b0; lf_tick = 1'b0;
      check(irq === ie, "R7 flag holds", irq, ie);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check(irq === 1'b0, "R7 clear pulse", irq, 0);
      repeat (total + 8) begin
         if (sel) lf_tick = 1'b1; else hf_tick = 1'b1;
         @(negedge clk);
      end
      hf_tick = 1'b0; lf_tick = 1'b0;
      irq_en = 1'b1;
      @(negedge clk);
      check(irq === 1'b0, "R6 stopped after expiry", irq, 0);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check(irq === 1'b0, "R9 reset state", irq, 0);
      rst_n = 1'b1;
      irq_en = 1'b1;
      repeat (40) begin
         hf_tick = 1'b1; lf_tick = 1'b1;
         @(negedge clk);
      end
      hf_tick = 1'b0; lf_tick = 1'b0;
      check(irq === 1'b0, "R9 idle ignores ticks", irq, 0);

      run_case(1'b0, 2'b10, 8'd3,  1'b1, 100, 0); // R2 divide by 2
      run_case(1'b1, 2'b11, 8'd5,  1'b1, 60,  0); // R1 slow source, R2 divide by 1
      run_case(1'b0, 2'b01, 8'd2,  1'b1, 70,  0); // R2 divide by 4
      run_case(1'b1, 2'b00, 8'd2,  1'b1, 50,  0); // R2 divide by 8
      run_case(1'b0, 2'b11, 8'd0,  1'b1, 100, 0); // R5 zero means 256 units
      run_case(1'b0, 2'b10, 8'd4,  1'b0, 80,  0); // R5 disabled request
      run_case(1'b1, 2'b10, 8'd1,  1'b1, 90,  1); // R7 clear in expiry cycle
      run_case(1'b0, 2'b11, 8'd3,  1'b1, 90,  2); // R8 restart in expiry cycle
      for (int i = 0; i < 16; i++) begin
         run_case(1'($urandom), 2'($urandom), CW'(1 + $urandom % 12),
                  1'($urandom % 4 != 0), 30 + int'($urandom % 70), 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule